// File: doc/BRIEF.md
# Scroll and Video-Memory Address Register File

This block is the processor-facing register file that holds the position state of a tile-based background renderer. It keeps a 15-bit current address, a 15-bit staging address, a 3-bit fine horizontal offset and a one-bit write toggle. The host processor reaches it through a window of eight byte-wide ports. The window repeats every eight addresses, so only the three low address bits choose the port.

Writes to the control, scroll and address ports update the staging address and the fine offset in three different bit layouts. The scroll and address ports share one first/second toggle. The second address-port byte copies the staging address into the current address. Every access to the data port steps the current address across (by 1) or down (by 32), depending on a control bit. Video memory itself, status flags and the updates made to the current address during rendering are outside this block.

The 15-bit addresses use this layout: fine vertical offset in bits 14..12, screen-page select in bits 11..10, tile row in bits 9..5 and tile column in bits 4..0.

Top module: `scroll_addr_regs`

## Requirements
- R1: After reset, the current address, staging address, fine offset, control byte and write toggle are all zero.
- R2: Only `cpu_addr[2:0]` selects a port (0 control, 2 status, 5 scroll, 6 address, 7 data). Every higher address bit is ignored.
- R3: A control-port write stores the whole byte in `ctrl_bits` and copies data bits 1..0 into staging bits 11..10.
- R4: A scroll-port write with the toggle at 0 puts data bits 7..3 into staging bits 4..0 and data bits 2..0 into `fine_x`. All other staging bits are unchanged.
- R5: A scroll-port write with the toggle at 1 puts data bits 7..3 into staging bits 9..5 and data bits 2..0 into staging bits 14..12. `fine_x` is unchanged.
- R6: An address-port write with the toggle at 0 puts data bits 5..0 into staging bits 13..8 and clears staging bit 14. The current address is unchanged.
- R7: An address-port write with the toggle at 1 puts the data byte into staging bits 7..0. In the same cycle, the current address takes the resulting staging value.
- R8: The scroll and address ports share one toggle, and every write to either port inverts it.
- R9: A read of the status port forces the toggle to 0.
- R10: A read or write of the data port adds 1 to the current address when control bit 2 is 0, and adds 32 when it is 1. The sum wraps modulo 2^15.
- R11: Writes to ports 1, 3 and 4, and reads of any port other than status and data, change no state, including the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Processor address; low 3 bits select the port |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cur_addr | output | 15 | Current address |
| tmp_addr | output | 15 | Staging address |
| fine_x | output | 3 | Fine horizontal offset |
| ctrl_bits | output | 8 | Last byte written to the control port |

## Verification
The bench interleaves the two toggle-sharing ports. A scroll byte followed by an address byte must act as the second address write. A design with separate toggles would leave the current address untouched.

It reads status between the bytes of a sequence. A design that ignores that read would treat the next byte as a second write.

It steps across the bit-14 carry and then around the full 15-bit range in steps of 32. A design that truncates the sum or misreads the step bit ends up at a different address.

It also writes through the unused ports and through high address mirrors. A design that decodes too many address bits, or that lets unused ports flip the toggle, changes state visibly.

// File: rtl/scroll_addr_regs.sv
module scroll_addr_regs #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [14:0]       cur_addr,
  output logic [14:0]       tmp_addr,
  output logic [2:0]        fine_x,
  output logic [7:0]        ctrl_bits
);
  localparam logic [2:0] P_CTRL   = 3'd0;
  localparam logic [2:0] P_STATUS = 3'd2;
  localparam logic [2:0] P_SCROLL = 3'd5;
  localparam logic [2:0] P_ADDR   = 3'd6;
  localparam logic [2:0] P_DATA   = 3'd7;

  logic [2:0]  port;
  logic        tog;
  logic [14:0] step;

  assign port = cpu_addr[2:0];
  assign step = ctrl_bits[2] ? 15'd32 : 15'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      tmp_addr  <= '0;
      fine_x    <= '0;
      ctrl_bits <= '0;
      tog       <= 1'b0;
    end else begin
      if (cpu_wr) begin
        case (port)
          P_CTRL: begin
            ctrl_bits       <= cpu_wdata;
            tmp_addr[11:10] <= cpu_wdata[1:0];
          end
          P_SCROLL: begin
            if (!tog) begin
              tmp_addr[4:0] <= cpu_wdata[7:3];
              fine_x        <= cpu_wdata[2:0];
            end else begin
              tmp_addr[9:5]   <= cpu_wdata[7:3];
              tmp_addr[14:12] <= cpu_wdata[2:0];
            end
            tog <= ~tog;
          end
          P_ADDR: begin
            if (!tog) begin
              tmp_addr[13:8] <= cpu_wdata[5:0];
              tmp_addr[14]   <= 1'b0;
            end else begin
              tmp_addr[7:0] <= cpu_wdata;
              cur_addr      <= {tmp_addr[14:8], cpu_wdata};
            end
            tog <= ~tog;
          end
          default: ;
        endcase
      end
      if (cpu_rd && port == P_STATUS) tog <= 1'b0;
      if ((cpu_rd || cpu_wr) && port == P_DATA) cur_addr <= cur_addr + step;
    end
  end

  p_ctrl_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && port == P_CTRL |=> tmp_addr[11:10] == $past(cpu_wdata[1:0]));

  p_scroll_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && port == P_SCROLL && !tog |=> fine_x == $past(cpu_wdata[2:0]));

  p_addr_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && port == P_ADDR && !tog |=> !tmp_addr[14] && $stable(cur_addr));

  p_addr_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && port == P_ADDR && tog |=> cur_addr == tmp_addr);

  p_toggle_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && (port == P_SCROLL || port == P_ADDR) |=> tog != $past(tog));

  p_status_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && !cpu_wr && port == P_STATUS |=> !tog);

  p_data_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd || cpu_wr) && port == P_DATA |=>
      cur_addr == 15'($past(cur_addr) + ($past(ctrl_bits[2]) ? 15'd32 : 15'd1)));
endmodule

// File: tb/scroll_addr_regs_tb_top.sv
`timescale 1ns/1ps
module scroll_addr_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [14:0] cur_addr, tmp_addr;
  logic [2:0]  fine_x;
  logic [7:0]  ctrl_bits;

  always #2.5 clk = ~clk;

  scroll_addr_regs #(.ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cur_addr(cur_addr), .tmp_addr(tmp_addr),
    .fine_x(fine_x), .ctrl_bits(ctrl_bits));

  int n_checks = 0;
  int n_fail = 0;

  logic [14:0] mv = '0, mt = '0;
  logic [2:0]  mx = '0;
  logic [7:0]  mc = '0;
  logic        mw = 1'b0;

  logic [40:0] expq[$];
  string       tagq[$];

  task automatic model(input logic wr, input logic rd, input logic [2:0] p, input logic [7:0] d);
    if (wr) begin
      if (p == 3'd0) begin mc = d; mt[11:10] = d[1:0]; end
      else if (p == 3'd5) begin
        if (!mw) begin mt[4:0] = d[7:3]; mx = d[2:0]; end
        else begin mt[9:5] = d[7:3]; mt[14:12] = d[2:0]; end
        mw = ~mw;
      end else if (p == 3'd6) begin
        if (!mw) begin mt[13:8] = d[5:0]; mt[14] = 1'b0; end
        else begin mt[7:0] = d; mv = mt; end
        mw = ~mw;
      end
    end
    if (rd && p == 3'd2) mw = 1'b0;
    if ((rd || wr) && p == 3'd7) mv = mv + (mc[2] ? 15'd32 : 15'd1);
  endtask

  task automatic acc(input logic wr, input logic rd, input logic [15:0] a,
                     input logic [7:0] d, input string tag);
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; cpu_addr = a; cpu_wdata = d;
    model(wr, rd, a[2:0], d);
    @(posedge clk);
    #1;
    expq.push_back({mv, mt, mx, mc});
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [40:0] e;
      string tg;
      e = expq.pop_front();
      tg = tagq.pop_front();
      n_checks++;
      if ({cur_addr, tmp_addr, fine_x, ctrl_bits} !== e) begin
        n_fail++;
        $display("FAIL %s: got v=%h t=%h x=%0d c=%h, expected v=%h t=%h x=%0d c=%h",
                 tg, cur_addr, tmp_addr, fine_x, ctrl_bits,
                 e[40:26], e[25:11], e[10:8], e[7:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if ({cur_addr, tmp_addr, fine_x, ctrl_bits} !== 41'd0) begin
      n_fail++;
      $display("FAIL R1: got v=%h t=%h x=%0d c=%h, expected all zero",
               cur_addr, tmp_addr, fine_x, ctrl_bits);
    end

    acc(1, 0, 16'h2000, 8'h03, "R3 control write");
    acc(1, 0, 16'h2005, 8'h7D, "R4 scroll first");
    acc(1, 0, 16'h200D, 8'h5E, "R5 R2 scroll second via mirror");
    acc(0, 1, 16'h2002, 8'h00, "R9 status read");
    acc(1, 0, 16'hFFF6, 8'hFF, "R6 R2 address first via high mirror");
    acc(1, 0, 16'h2006, 8'h10, "R7 address second copies");
    acc(1, 0, 16'h2007, 8'hAA, "R10 data write step 1");
    acc(0, 1, 16'h200F, 8'h00, "R10 data read step 1");

    acc(1, 0, 16'h2001, 8'hFF, "R11 port1 write ignored");
    acc(1, 0, 16'h2003, 8'hFF, "R11 port3 write ignored");
    acc(1, 0, 16'h2004, 8'hFF, "R11 port4 write ignored");
    acc(0, 1, 16'h2005, 8'h00, "R11 scroll read ignored");
    acc(0, 1, 16'h2006, 8'h00, "R11 address read ignored");
    acc(1, 0, 16'h2006, 8'h21, "R6 address first after ignored traffic");
    acc(1, 0, 16'h2001, 8'hFF, "R11 port1 write between bytes");
    acc(0, 1, 16'h2000, 8'h00, "R11 control read between bytes");
    acc(1, 0, 16'h2006, 8'h34, "R7 R11 toggle kept, v=2134");

    acc(1, 0, 16'h2005, 8'h00, "R8 scroll first sets toggle");
    acc(1, 0, 16'h2006, 8'h12, "R8 address acts as second");

    acc(1, 0, 16'h2006, 8'h3F, "R6 address first");
    acc(0, 1, 16'h2002, 8'h00, "R9 status read mid sequence");
    acc(1, 0, 16'h2006, 8'h3F, "R9 address treated as first");
    acc(1, 0, 16'h2006, 8'hE0, "R7 v=3FE0");
    acc(1, 0, 16'h2000, 8'h04, "R3 control step-down bit");
    acc(1, 0, 16'h2007, 8'h00, "R10 step 32 carry into bit 14");

    for (int i = 0; i < 1024; i++) acc(0, 1, 16'h2007, 8'h00, "R10 step 32 wrap");

    acc(1, 0, 16'h2000, 8'h00, "R3 back to step 1");
    acc(0, 1, 16'h2002, 8'h00, "R9 status clears toggle");
    acc(1, 0, 16'h2005, 8'hFF, "R4 scroll first all ones");
    acc(1, 0, 16'h2005, 8'hFF, "R5 scroll second all ones");
    acc(1, 0, 16'h2000, 8'h07, "R3 page 3 and step 32");

    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule